// File: doc/BRIEF.md
# SPI Burst Engine

This block is the serial engine of an SPI master. It moves 8-bit frames from an external transmit FIFO onto MOSI and assembles bits from MISO into bytes for an external receive FIFO. A single control word sets the frame format and the chip-select behaviour, and it can start a burst. The burst length and the transmit length are presented as separate 24-bit counts and are captured when the burst starts. The engine clocks the full burst length. It pops the transmit FIFO only for the first transmit-length frames. For every frame after that it sends zero.

SCLK edges are paced by a `tick` input from an external divider. Each tick advances the serial clock by one half period. Chip select is driven either automatically around the burst or manually at a level given in the control word. When the last frame of the burst has been clocked, the engine clears its busy bit and pulses a transfer-complete strobe.

Top module: `spi_burst_engine`

## Requirements
- R1: After reset, the control word reads 0, SCLK and MOSI are low, all four chip-select lines are high, and no pop, push or completion strobe is active.
- R2: A control write with bit 31 set and a nonzero burst length starts a burst. Bit 31 then reads 1 until the last frame ends and reads 0 from the next cycle, the same cycle in which `xfer_done` pulses high for one cycle. With a burst length of 0, no frame is clocked and `xfer_done` pulses in the cycle after the write.
- R3: The control word layout is as follows: bit 0 clock phase, bit 1 clock polarity, bit 2 select polarity (1 = active high), bits 5:4 select index, bit 6 manual select, bit 7 manual level, bit 8 receive discard, bit 12 LSB-first, bit 31 busy/start. Every other bit reads 0.
- R4: A frame is 8 bits and each bit takes two ticks. SCLK toggles on every tick consumed inside a frame and rests at the clock-polarity level between frames and while idle.
- R5: With clock phase 0, MISO is sampled on the first tick of each bit. With clock phase 1, it is sampled on the second tick. The received byte is delivered with the push.
- R6: MOSI holds each data bit for the whole two-tick bit window. The bit order is MSB first, or LSB first when bit 12 is set, and the same order applies to received bits.
- R7: Exactly the first transmit-length frames pop the transmit FIFO, one pop per frame in the cycle before that frame starts. The remaining frames of the burst send 0 and do not pop.
- R8: If the transmit FIFO is empty while transmit frames remain, the engine waits between frames with SCLK at rest and ignores ticks. It continues as soon as data is present.
- R9: At the tick that ends each frame, `rx_push` pulses with the received byte, unless bit 8 is set. In that case no push occurs.
- R10: Only the selected line can leave its inactive level, which is the inverse of the select polarity. In automatic mode, the selected line is active while busy. In manual mode, it follows the manual level bit at all times.
- R11: Control writes made while a burst is in progress are ignored, including their start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| burst_len | input | 24 | Total frames in the burst, captured at start |
| tx_len | input | 24 | Frames taken from the transmit FIFO, captured at start |
| cfg_rdata | output | 32 | Control word readback with busy in bit 31 |
| tick | input | 1 | Half-bit pacing strobe from the divider |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | 8 | Transmit FIFO head (first-word fall-through) |
| tx_pop | output | 1 | Transmit FIFO pop |
| rx_data | output | 8 | Received byte |
| rx_push | output | 1 | Receive FIFO push |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_lines | output | 4 | Chip-select lines |
| xfer_done | output | 1 | One-cycle burst-complete strobe |

## Verification
The assertions assume that `tx_data` is valid whenever `tx_empty` is low, and that the FIFOs accept a pop or push in any cycle. They also assume that `tick` is a one-cycle strobe that the engine may ignore while it is not inside a frame. The stimulus keeps a queue as the transmit FIFO and presents its head only when the queue is non-empty. It pops the queue only when the reference model predicts a pop. It paces `tick` every cycle or every third cycle, and it toggles MISO from a shift register so that the two sampling edges see different values. The stall case empties the queue in the middle of a burst, and control writes are issued both while idle and while busy.

// File: rtl/spi_seq_pkg.sv
`timescale 1ns/1ps
package spi_seq_pkg;

  localparam int CPHA_B   = 0;
  localparam int CPOL_B   = 1;
  localparam int ACTHI_B  = 2;
  localparam int SEL_LO_B = 4;
  localparam int MAN_B    = 6;
  localparam int LVL_B    = 7;
  localparam int DISC_B   = 8;
  localparam int LSB_B    = 12;
  localparam int START_B  = 31;
  localparam int SEL_W    = 2;

  typedef struct packed {
    logic             lsb_first;
    logic             rx_discard;
    logic             man_level;
    logic             man_en;
    logic [SEL_W-1:0] sel;
    logic             act_hi;
    logic             cpol;
    logic             cpha;
  } xfer_cfg_t;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_LOAD, SEQ_SHIFT} seq_state_e;

  function automatic xfer_cfg_t unpack_cfg(input logic [31:0] w);
    xfer_cfg_t c;
    c.cpha       = w[CPHA_B];
    c.cpol       = w[CPOL_B];
    c.act_hi     = w[ACTHI_B];
    c.sel        = w[SEL_LO_B +: SEL_W];
    c.man_en     = w[MAN_B];
    c.man_level  = w[LVL_B];
    c.rx_discard = w[DISC_B];
    c.lsb_first  = w[LSB_B];
    return c;
  endfunction

  function automatic logic [31:0] pack_cfg(input xfer_cfg_t c, input logic busy);
    logic [31:0] w;
    w                    = '0;
    w[CPHA_B]            = c.cpha;
    w[CPOL_B]            = c.cpol;
    w[ACTHI_B]           = c.act_hi;
    w[SEL_LO_B +: SEL_W] = c.sel;
    w[MAN_B]             = c.man_en;
    w[LVL_B]             = c.man_level;
    w[DISC_B]            = c.rx_discard;
    w[LSB_B]             = c.lsb_first;
    w[START_B]           = busy;
    return w;
  endfunction

endpackage

// File: rtl/spi_frame_shifter.sv
`timescale 1ns/1ps
module spi_frame_shifter #(
  parameter int FRAME_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] load_byte,
  input  logic                  run,
  input  logic                  tick,
  input  logic                  cpol,
  input  logic                  cpha,
  input  logic                  lsb_first,
  input  logic                  miso,
  output logic                  sclk,
  output logic                  mosi,
  output logic                  frame_end,
  output logic [FRAME_BITS-1:0] rx_byte
);
  localparam int              CNT_W    = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] tx_q, tx_d, rx_q, rx_d;
  logic [CNT_W-1:0]      bit_q, bit_d, out_idx;
  logic                  half_q, half_d;

  function automatic logic [FRAME_BITS-1:0] shift_in(input logic [FRAME_BITS-1:0] v,
                                                     input logic b, input logic lsb);
    return lsb ? {b, v[FRAME_BITS-1:1]} : {v[FRAME_BITS-2:0], b};
  endfunction

  always_comb begin
    tx_d   = tx_q;
    rx_d   = rx_q;
    bit_d  = bit_q;
    half_d = half_q;
    if (load) begin
      tx_d   = load_byte;
      bit_d  = '0;
      half_d = 1'b0;
    end else if (run && tick) begin
      if (!half_q) begin
        half_d = 1'b1;
        if (!cpha) rx_d = shift_in(rx_q, miso, lsb_first);
      end else begin
        half_d = 1'b0;
        bit_d  = (bit_q == LAST_IDX) ? '0 : bit_q + CNT_W'(1);
        if (cpha) rx_d = shift_in(rx_q, miso, lsb_first);
      end
    end
  end

  assign out_idx   = lsb_first ? bit_q : LAST_IDX - bit_q;
  assign mosi      = run & tx_q[out_idx];
  assign sclk      = cpol ^ half_q;
  assign frame_end = run & tick & half_q & (bit_q == LAST_IDX);
  assign rx_byte   = cpha ? shift_in(rx_q, miso, lsb_first) : rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      half_q <= 1'b0;
    end else begin
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      bit_q  <= bit_d;
      half_q <= half_d;
    end
  end

  // R4: the serial clock phase only moves on a tick
  a_r4_sclk_waits_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ((sclk ^ cpol) == $past(sclk ^ cpol)));
  // R4: a finished frame leaves SCLK at rest
  a_r4_rest_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (sclk == cpol));

endmodule

// File: rtl/spi_cs_drive.sv
`timescale 1ns/1ps
module spi_cs_drive #(
  parameter int NUM_CS = 4,
  parameter int SEL_W  = 2
) (
  input  logic             act_hi,
  input  logic [SEL_W-1:0] sel,
  input  logic             man_en,
  input  logic             man_level,
  input  logic             busy,
  output logic [NUM_CS-1:0] cs_lines
);
  logic auto_level;
  assign auto_level = busy ? act_hi : ~act_hi;

  for (genvar k = 0; k < NUM_CS; k++) begin : g_line
    assign cs_lines[k] = (sel == SEL_W'(k)) ? (man_en ? man_level : auto_level) : ~act_hi;
  end

endmodule

// File: rtl/spi_burst_engine.sv
`timescale 1ns/1ps
module spi_burst_engine
  import spi_seq_pkg::*;
#(
  parameter int CNT_W      = 24,
  parameter int FRAME_BITS = 8,
  parameter int NUM_CS     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [31:0]           cfg_wdata,
  input  logic [CNT_W-1:0]      burst_len,
  input  logic [CNT_W-1:0]      tx_len,
  output logic [31:0]           cfg_rdata,
  input  logic                  tick,
  input  logic                  tx_empty,
  input  logic [FRAME_BITS-1:0] tx_data,
  output logic                  tx_pop,
  output logic [FRAME_BITS-1:0] rx_data,
  output logic                  rx_push,
  input  logic                  miso,
  output logic                  sclk,
  output logic                  mosi,
  output logic [NUM_CS-1:0]     cs_lines,
  output logic                  xfer_done
);
  xfer_cfg_t             cfg_q, cfg_d;
  seq_state_e            st_q, st_d;
  logic [CNT_W-1:0]      burst_q, burst_d, xmit_q, xmit_d;
  logic                  done_q, done_d;
  logic                  load, frame_end, busy, run;
  logic [FRAME_BITS-1:0] load_byte;
  logic                  spare_bits_unused;

  assign spare_bits_unused = ^{cfg_wdata[30:13], cfg_wdata[11:9], cfg_wdata[3]};

  always_comb begin
    cfg_d     = cfg_q;
    st_d      = st_q;
    burst_d   = burst_q;
    xmit_d    = xmit_q;
    done_d    = 1'b0;
    load      = 1'b0;
    load_byte = '0;
    tx_pop    = 1'b0;
    unique case (st_q)
      SEQ_IDLE: if (cfg_we) begin
        cfg_d = unpack_cfg(cfg_wdata);
        if (cfg_wdata[START_B]) begin
          if (burst_len == '0) begin
            done_d = 1'b1;
          end else begin
            burst_d = burst_len;
            xmit_d  = tx_len;
            st_d    = SEQ_LOAD;
          end
        end
      end
      SEQ_LOAD: if (xmit_q != '0) begin
        if (!tx_empty) begin
          tx_pop    = 1'b1;
          load      = 1'b1;
          load_byte = tx_data;
          xmit_d    = xmit_q - CNT_W'(1);
          st_d      = SEQ_SHIFT;
        end
      end else begin
        load = 1'b1;
        st_d = SEQ_SHIFT;
      end
      SEQ_SHIFT: if (frame_end) begin
        burst_d = burst_q - CNT_W'(1);
        if (burst_q == CNT_W'(1)) begin
          st_d   = SEQ_IDLE;
          done_d = 1'b1;
        end else begin
          st_d = SEQ_LOAD;
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      st_q    <= SEQ_IDLE;
      burst_q <= '0;
      xmit_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      st_q    <= st_d;
      burst_q <= burst_d;
      xmit_q  <= xmit_d;
      done_q  <= done_d;
    end
  end

  assign busy      = (st_q != SEQ_IDLE);
  assign run       = (st_q == SEQ_SHIFT);
  assign cfg_rdata = pack_cfg(cfg_q, busy);
  assign xfer_done = done_q;
  assign rx_push   = frame_end & ~cfg_q.rx_discard;

  spi_frame_shifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_byte(load_byte), .run(run),
    .tick(tick), .cpol(cfg_q.cpol), .cpha(cfg_q.cpha), .lsb_first(cfg_q.lsb_first),
    .miso(miso), .sclk(sclk), .mosi(mosi), .frame_end(frame_end), .rx_byte(rx_data)
  );

  spi_cs_drive #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_cs (
    .act_hi(cfg_q.act_hi), .sel(cfg_q.sel), .man_en(cfg_q.man_en),
    .man_level(cfg_q.man_level), .busy(busy), .cs_lines(cs_lines)
  );

  // R2: the completion strobe only appears once the engine is idle
  a_r2_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (cfg_rdata[START_B] == 1'b0));
  // R8: a pop is only issued when the FIFO holds data
  a_r8_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);
  // R8: waiting between frames keeps SCLK at rest
  a_r8_rest_while_loading: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_LOAD) |-> (sclk == cfg_q.cpol));
  // R7: the transmit count only drops on a pop
  a_r7_count_tracks_pop: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == SEQ_LOAD && st_q == SEQ_SHIFT && xmit_q != $past(xmit_q)) |-> $past(tx_pop));
  // R9: a push marks the end of a frame, after which SCLK rests
  a_r9_push_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> (sclk == cfg_q.cpol));
  // R11: configuration stays frozen during a burst
  a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg_q));
  // R10: at most one line away from its inactive level
  a_r10_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cs_lines ^ {NUM_CS{~cfg_q.act_hi}}) <= 1);

endmodule

// File: tb/test_spi_burst_engine.sv
`timescale 1ns/1ps
module test_spi_burst_engine;
  localparam int CW = 24;

  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic          cfg_we, tick, tx_empty, miso;
  logic [31:0]   cfg_wdata, cfg_rdata;
  logic [CW-1:0] burst_len, tx_len;
  logic [7:0]    tx_data, rx_data;
  logic          tx_pop, rx_push, sclk, mosi, xfer_done;
  logic [3:0]    cs_lines;

  spi_burst_engine i_spi_burst_engine (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .burst_len(burst_len), .tx_len(tx_len), .cfg_rdata(cfg_rdata), .tick(tick),
    .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop), .rx_data(rx_data),
    .rx_push(rx_push), .miso(miso), .sclk(sclk), .mosi(mosi),
    .cs_lines(cs_lines), .xfer_done(xfer_done)
  );

  // reference model state
  bit m_busy, m_inframe, m_done;
  bit m_cpha, m_cpol, m_act, m_man, m_lvl, m_disc, m_lsb;
  int m_sel, m_burst, m_xmit, m_edge;
  bit [7:0] m_tx;
  bit m_smp [8];
  logic [7:0] fifo_q [$];

  int n_chk = 0, n_bad = 0, tick_div = 1, tick_cnt = 0;
  bit finished = 0;
  logic [15:0] lfsr = 16'hACE1;
  string ctx = "R1 reset";

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] actual %0h expected %0h", req, ctx, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit cpha, bit cpol, bit act, int sel, bit man,
                                     bit lvl, bit disc, bit lsb, bit start);
    logic [31:0] w = '0;
    w[0] = cpha; w[1] = cpol; w[2] = act; w[5:4] = sel[1:0];
    w[6] = man; w[7] = lvl; w[8] = disc; w[12] = lsb; w[31] = start;
    return w;
  endfunction

  task automatic step();
    bit fin, e_sclk, e_mosi, e_pop, e_push, nd;
    bit smp_c [8];
    logic [7:0] e_rx;
    logic [3:0] e_cs;
    logic [31:0] e_rd;
    int bn;
    tick     = (tick_cnt % tick_div) == 0;
    tick_cnt++;
    miso     = lfsr[0];
    lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_empty = (fifo_q.size() == 0);
    tx_data  = tx_empty ? 8'h00 : fifo_q[0];
    #1;
    bn     = m_edge / 2;
    e_sclk = m_cpol ^ (m_inframe && (m_edge % 2 == 1));
    e_mosi = m_inframe ? m_tx[m_lsb ? bn : 7 - bn] : 1'b0;
    e_pop  = m_busy && !m_inframe && m_xmit > 0 && !tx_empty;
    fin    = m_inframe && tick && m_edge == 15;
    e_push = fin && !m_disc;
    smp_c  = m_smp;
    if (fin && m_cpha) smp_c[7] = miso;
    for (int i = 0; i < 8; i++) e_rx[m_lsb ? i : 7 - i] = smp_c[i];
    for (int k = 0; k < 4; k++)
      e_cs[k] = (k == m_sel) ? (m_man ? m_lvl : (m_busy ? m_act : !m_act)) : !m_act;
    e_rd = mk(m_cpha, m_cpol, m_act, m_sel, m_man, m_lvl, m_disc, m_lsb, m_busy);
    chk("R4 sclk", sclk, e_sclk);
    chk("R6 mosi", mosi, e_mosi);
    chk("R7 tx_pop", tx_pop, e_pop);
    chk("R9 rx_push", rx_push, e_push);
    if (e_push) chk("R5 rx_data", rx_data, e_rx);
    chk("R10 cs_lines", cs_lines, e_cs);
    chk("R2 xfer_done", xfer_done, m_done);
    chk("R3 cfg_rdata", cfg_rdata, e_rd);
    nd = 0;
    if (m_busy) begin
      if (m_inframe) begin
        if (tick) begin
          if ((m_edge % 2 == 0 && !m_cpha) || (m_edge % 2 == 1 && m_cpha))
            m_smp[m_edge / 2] = miso;
          m_edge++;
          if (m_edge == 16) begin
            m_inframe = 0;
            m_burst--;
            if (m_burst == 0) begin m_busy = 0; nd = 1; end
          end
        end
      end else if (m_xmit > 0) begin
        if (!tx_empty) begin
          m_tx = fifo_q[0]; m_xmit--; m_inframe = 1; m_edge = 0;
        end
      end else begin
        m_tx = 8'h00; m_inframe = 1; m_edge = 0;
      end
    end else if (cfg_we) begin
      m_cpha = cfg_wdata[0]; m_cpol = cfg_wdata[1]; m_act = cfg_wdata[2];
      m_sel = int'(cfg_wdata[5:4]); m_man = cfg_wdata[6]; m_lvl = cfg_wdata[7];
      m_disc = cfg_wdata[8]; m_lsb = cfg_wdata[12];
      if (cfg_wdata[31]) begin
        if (burst_len == 0) nd = 1;
        else begin m_busy = 1; m_burst = int'(burst_len); m_xmit = int'(tx_len); end
      end
    end
    m_done = nd;
    if (e_pop) void'(fifo_q.pop_front());
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic cfg_wr(logic [31:0] w, int bl, int tl);
    cfg_we = 1; cfg_wdata = w; burst_len = CW'(bl); tx_len = CW'(tl);
    step();
    cfg_we = 0;
  endtask

  task automatic run_to_idle();
    for (int i = 0; i < 5000 && m_busy; i++) step();
    run(3);
  endtask

  initial begin
    rst_n = 0; cfg_we = 0; cfg_wdata = '0; burst_len = '0; tx_len = '0;
    tick = 0; tx_empty = 1; tx_data = '0; miso = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    run(4);                                       // R1 reset state

    ctx = "R5 R6 mode 0 msb first";
    fifo_q.push_back(8'hA5); fifo_q.push_back(8'h3C); fifo_q.push_back(8'hF0);
    cfg_wr(mk(0, 0, 0, 1, 0, 0, 0, 0, 1), 3, 3);
    run_to_idle();

    ctx = "R7 phase 1 lsb first zero fill";
    tick_div = 3;
    fifo_q.push_back(8'h81); fifo_q.push_back(8'h6E);
    cfg_wr(mk(1, 1, 1, 2, 0, 0, 0, 1, 1), 4, 2);
    run_to_idle();

    ctx = "R9 receive discard";
    tick_div = 1;
    fifo_q.push_back(8'h5A); fifo_q.push_back(8'hC3);
    cfg_wr(mk(0, 1, 0, 0, 0, 0, 1, 0, 1), 2, 2);
    run_to_idle();

    ctx = "R8 stall on empty fifo";
    fifo_q.push_back(8'h11);
    cfg_wr(mk(1, 0, 0, 3, 0, 0, 0, 0, 1), 3, 3);
    run(80);
    fifo_q.push_back(8'h22); fifo_q.push_back(8'h33);
    run_to_idle();

    ctx = "R10 manual select";
    cfg_wr(mk(0, 0, 0, 3, 1, 0, 0, 0, 0), 0, 0);
    run(5);
    fifo_q.push_back(8'h9D);
    cfg_wr(mk(0, 0, 0, 3, 1, 1, 0, 0, 1), 1, 1);
    run_to_idle();

    ctx = "R11 write while busy";
    fifo_q.push_back(8'h47); fifo_q.push_back(8'hB2);
    cfg_wr(mk(0, 0, 1, 1, 0, 0, 0, 0, 1), 2, 2);
    run(6);
    cfg_wr(mk(1, 1, 0, 2, 1, 1, 1, 1, 1), 7, 0);
    run_to_idle();

    ctx = "R2 zero length burst";
    cfg_wr(mk(0, 0, 0, 0, 0, 0, 0, 0, 1), 0, 0);
    run(4);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog [%s] actual hung expected finished", ctx);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule